// File: doc/BRIEF.md
# Chip-Select Gated Serial Frame Loader

This block receives display frames over a three-wire serial link made of a serial clock, a data line and an active-low chip select. While chip select is low, every rising edge of the serial clock moves one data bit into a 112-bit shift register. The new bit enters at the top position, 112, and the older contents move one place down toward position 1. All three serial inputs are first synchronised into the system clock domain. Edges are found there, so no flop runs on the serial clock itself.

When chip select returns high, the bit now at position 112 is the mode bit. If it is 1, positions 1 to 111 are copied into the display latch. If it is 0, positions 97 to 106 are copied into the 10-bit dimming latch. The latch that was not chosen keeps its value. The shift register is not cleared between frames. A short 16-bit dimming frame therefore leaves older bits in the lower positions, and those bits are simply not used.

A synchronous active-low reset, driven from a power-on-reset source, clears the shift register and both latches.

Top module: `serial_frame_loader`

## Requirements
- R1: While `rst_n` is low at a clock edge, the shift register, `disp_q` and `dim_q` are cleared to zero.
- R2: Rising edges of `ser_clk` while `cs_n` is high leave the shift register unchanged.
- R3: Each accepted serial clock rise places `ser_data` at position 112 and moves every other bit down by one place. After 112 bits, the first bit sent sits at position 1.
- R4: `disp_q` and `dim_q` change only as a result of a rising edge of `cs_n`, or a reset.
- R5: On a rising edge of `cs_n` with position 112 equal to 1, `disp_q[i-1]` takes position i for i = 1 to 111. Bit 0 is therefore the first bit of a 112-bit frame. `dim_q` is unchanged.
- R6: On a rising edge of `cs_n` with position 112 equal to 0, `dim_q[j]` takes position 97+j for j = 0 to 9. The first bit of a 16-bit frame is therefore the dimming LSB. `disp_q` is unchanged.
- R7: In a 16-bit dimming frame, the five bits at positions 107 to 111 (bits 11 to 15 sent) have no effect on `dim_q`.
- R8: A rising edge of `cs_n` does not clear the shift register. A frame shorter than 112 bits therefore combines its bits with the older bits that have moved down into the lower positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset from the power-on-reset source |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data line |
| cs_n | input | 1 | Active-low chip select; its rising edge ends a frame |
| disp_q | output | 111 | Display data latch; bit i-1 holds position i |
| dim_q | output | 10 | Dimming value latch |

## Verification
The assertions check on every cycle that the shift register is frozen while chip select is high. They also check each single-step move into position 112, that the latches hold still away from a chip-select rise, and that a rise loads exactly one latch from the right slice. Only the bench scenarios can show the end-to-end behaviour: how bits map to latch positions after a full frame through the synchronisers, that the don't-care bits are ignored, and how a short frame combines with older contents. The bench covers a sweep of dimming values, walking and mixed display patterns, and partial frames.

// File: rtl/loader_pkg.sv
// Package: shared sizes of the serial frame loader.
// Assumes positions are numbered from 1 (first stored) up to the frame width.
package loader_pkg;
    localparam int unsigned FRAME_BITS   = 112;
    localparam int unsigned DISP_BITS    = 111;
    localparam int unsigned DIM_BITS     = 10;
    localparam int unsigned DIM_LOW_POS  = 97;   // 1-based position of dimming LSB
    localparam int unsigned SYNC_DEPTH   = 2;
endpackage

// File: rtl/loader_sync.sv
// Module: loader_sync
// Synchronises a vector of slow asynchronous inputs through a flop chain.
// Assumes inputs stay stable for several system clocks between changes.
module loader_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] IDLE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // capture the raw input into the first stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= IDLE;
                else        chain[0] <= async_in;
            end
        end else begin : g_next
            // pass each value one stage further along the chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= IDLE;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/loader_edge.sv
// Module: loader_edge
// Flags a rising edge on each bit of an already synchronised vector.
// Assumes the reset value matches the idle level, so reset gives no false edge.
module loader_edge #(
    parameter int unsigned WIDTH = 2,
    parameter logic [WIDTH-1:0] IDLE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_q;

    // keep the previous level of each bit
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= IDLE;
        else        prev_q <= level;
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign rise[b] = level[b] & ~prev_q[b];
    end
endmodule

// File: rtl/loader_shift.sv
// Module: loader_shift
// Frame shift register: a new bit enters the top, the rest move toward bit 0.
// Assumes shift_en already accounts for chip select; it is never cleared by a frame end.
module loader_shift #(
    parameter int unsigned WIDTH = 112
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] sreg
);
    // move one bit in at the top on each enabled step
    always_ff @(posedge clk) begin
        if (!rst_n)        sreg <= '0;
        else if (shift_en) sreg <= {bit_in, sreg[WIDTH-1:1]};
    end
endmodule

// File: rtl/loader_latch.sv
// Module: loader_latch
// Two target latches. The mode bit (top of the frame) picks which one loads.
// Assumes load is a single-cycle pulse and sreg is stable in that cycle.
module loader_latch #(
    parameter int unsigned FRAME_W = 112,
    parameter int unsigned DISP_W  = 111,
    parameter int unsigned DIM_W   = 10,
    parameter int unsigned DIM_LSB = 96    // 0-based index of the dimming LSB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] sreg,
    output logic [DISP_W-1:0]  disp_q,
    output logic [DIM_W-1:0]   dim_q
);
    localparam int unsigned MODE_IDX = FRAME_W - 1;

    logic mode_disp;
    assign mode_disp = sreg[MODE_IDX];

    // display latch takes the lower positions when the mode bit is set
    always_ff @(posedge clk) begin
        if (!rst_n)                  disp_q <= '0;
        else if (load && mode_disp)  disp_q <= sreg[DISP_W-1:0];
    end

    // dimming latch takes its slice when the mode bit is clear
    always_ff @(posedge clk) begin
        if (!rst_n)                  dim_q <= '0;
        else if (load && !mode_disp) dim_q <= sreg[DIM_LSB +: DIM_W];
    end
endmodule

// File: rtl/serial_frame_loader.sv
// Module: serial_frame_loader
// Three-wire serial receiver. It shifts bits in while chip select is low and,
// when chip select rises, loads the display or dimming latch as the mode bit selects.
// Assumes serial signals are slow relative to clk (each level held >= 3 cycles).
module serial_frame_loader #(
    parameter int unsigned FRAME_W   = loader_pkg::FRAME_BITS,
    parameter int unsigned DISP_W    = loader_pkg::DISP_BITS,
    parameter int unsigned DIM_W     = loader_pkg::DIM_BITS,
    parameter int unsigned DIM_POS   = loader_pkg::DIM_LOW_POS,
    parameter int unsigned SYNC_W    = loader_pkg::SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              cs_n,
    output logic [DISP_W-1:0] disp_q,
    output logic [DIM_W-1:0]  dim_q
);
    localparam int unsigned DIM_LSB = DIM_POS - 1;

    // synchronised levels: bit 2 data, bit 1 chip select, bit 0 serial clock
    logic [2:0] lvl;
    logic [1:0] rises;
    logic       sclk_rise;
    logic       cs_rise;
    logic       cs_lvl;
    logic       data_lvl;
    logic       shift_en;
    logic [FRAME_W-1:0] sreg_q;

    loader_sync #(.WIDTH(3), .STAGES(SYNC_W), .IDLE(3'b010)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_data, cs_n, ser_clk}),
        .sync_out (lvl)
    );

    assign data_lvl = lvl[2];
    assign cs_lvl   = lvl[1];

    loader_edge #(.WIDTH(2), .IDLE(2'b10)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (lvl[1:0]),
        .rise  (rises)
    );

    assign sclk_rise = rises[0];
    assign cs_rise   = rises[1];
    assign shift_en  = sclk_rise & ~cs_lvl;

    loader_shift #(.WIDTH(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (data_lvl),
        .sreg     (sreg_q)
    );

    loader_latch #(
        .FRAME_W (FRAME_W),
        .DISP_W  (DISP_W),
        .DIM_W   (DIM_W),
        .DIM_LSB (DIM_LSB)
    ) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cs_rise),
        .sreg   (sreg_q),
        .disp_q (disp_q),
        .dim_q  (dim_q)
    );
endmodule

// File: rtl/loader_checker.sv
// Module: loader_checker
// Property checks for serial_frame_loader, attached by bind below.
module loader_checker #(
    parameter int unsigned FRAME_W = 112,
    parameter int unsigned DISP_W  = 111,
    parameter int unsigned DIM_W   = 10,
    parameter int unsigned DIM_LSB = 96
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_lvl,
    input logic               data_lvl,
    input logic               sclk_rise,
    input logic               cs_rise,
    input logic [FRAME_W-1:0] sreg,
    input logic [DISP_W-1:0]  disp_q,
    input logic [DIM_W-1:0]   dim_q
);
    logic reset_seen = 1'b0;

    // note whether the previous edge was a reset edge
    always_ff @(posedge clk) reset_seen <= !rst_n;

    // R1: one edge after a reset edge, everything is zero
    always @(posedge clk) begin
        if (reset_seen)
            assert_reset_clear_R1: assert (sreg == '0 && disp_q == '0 && dim_q == '0);
    end

    assert_cs_high_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |=> $stable(sreg));

    assert_shift_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && !cs_lvl) |=>
            (sreg[FRAME_W-1] == $past(data_lvl)) && (sreg[FRAME_W-2:0] == $past(sreg[FRAME_W-1:1])));

    assert_latch_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> ($stable(disp_q) && $stable(dim_q)));

    assert_disp_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && sreg[FRAME_W-1]) |=>
            (disp_q == $past(sreg[DISP_W-1:0])) && $stable(dim_q));

    assert_dim_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !sreg[FRAME_W-1]) |=>
            (dim_q == $past(sreg[DIM_LSB +: DIM_W])) && $stable(disp_q));

    assert_no_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> $stable(sreg));
endmodule

bind serial_frame_loader loader_checker #(
    .FRAME_W (FRAME_W),
    .DISP_W  (DISP_W),
    .DIM_W   (DIM_W),
    .DIM_LSB (DIM_LSB)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_lvl    (cs_lvl),
    .data_lvl  (data_lvl),
    .sclk_rise (sclk_rise),
    .cs_rise   (cs_rise),
    .sreg      (sreg_q),
    .disp_q    (disp_q),
    .dim_q     (dim_q)
);

// File: tb/test_serial_frame_loader.sv
module test_serial_frame_loader;
    localparam int FW = 112;
    localparam int DW = 111;
    localparam int MW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b1;
    logic ser_data = 1'b0;
    logic cs_n = 1'b1;
    logic [DW-1:0] disp_q;
    logic [MW-1:0] dim_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model, built from the requirements
    logic [FW-1:0] model = '0;
    logic [DW-1:0] exp_disp = '0;
    logic [MW-1:0] exp_dim = '0;

    always #4 clk = ~clk;   // 125 MHz

    serial_frame_loader i_serial_frame_loader (
        .clk (clk), .rst_n (rst_n), .ser_clk (ser_clk), .ser_data (ser_data),
        .cs_n (cs_n), .disp_q (disp_q), .dim_q (dim_q)
    );

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_disp(input string req);
        checks++;
        if (disp_q !== exp_disp) begin
            errors++;
            $display("FAIL %s disp actual %h expected %h", req, disp_q, exp_disp);
        end
    endtask

    task automatic check_dim(input string req);
        checks++;
        if (dim_q !== exp_dim) begin
            errors++;
            $display("FAIL %s dim actual %h expected %h", req, dim_q, exp_dim);
        end
    endtask

    // one serial bit: data set with clock low, then clock rises (R3)
    task automatic send_bit(input logic b, input bit selected);
        ser_clk = 1'b0;
        ser_data = b;
        wait_cyc(3);
        ser_clk = 1'b1;
        wait_cyc(3);
        if (selected) model = {b, model[FW-1:1]};
    endtask

    // frame: vec[0] goes first, n bits, then chip select rises
    task automatic send_frame(input logic [FW-1:0] vec, input int n);
        cs_n = 1'b0;
        wait_cyc(3);
        for (int i = 0; i < n; i++) send_bit(vec[i], 1'b1);
        wait_cyc(2);
        check_disp("R4 before cs rise");
        check_dim("R4 before cs rise");
        cs_n = 1'b1;
        if (model[FW-1]) exp_disp = model[DW-1:0];
        else             exp_dim  = model[96 +: MW];
        wait_cyc(8);
    endtask

    function automatic logic [FW-1:0] dim_frame(input logic [MW-1:0] v, input logic [4:0] junk);
        logic [FW-1:0] f = '0;
        f[MW-1:0] = v;
        f[14:10] = junk;
        f[15] = 1'b0;
        return f;
    endfunction

    initial begin
        wait_cyc(4);
        // R1: reset state
        check_disp("R1 reset");
        check_dim("R1 reset");
        rst_n = 1'b1;
        wait_cyc(4);
        check_disp("R1 after release");
        check_dim("R1 after release");

        // R5: walking one across display positions, mode bit set
        for (int p = 0; p < DW; p += 10) begin
            logic [FW-1:0] f = '0;
            f[p] = 1'b1;
            f[FW-1] = 1'b1;
            send_frame(f, FW);
            check_disp("R5 walking one");
            check_dim("R5 dim unchanged");
        end
        // R3/R5: mixed patterns, first bit lands in disp_q[0]
        for (int k = 0; k < 6; k++) begin
            logic [FW-1:0] f;
            for (int i = 0; i < FW; i++) f[i] = logic'(((i * (k + 3)) + k) % 5 < 2);
            f[FW-1] = 1'b1;
            send_frame(f, FW);
            check_disp("R3 bit order");
        end

        // R6/R7: dimming sweep with varying don't-care bits
        for (int v = 0; v < 1024; v += 7) begin
            send_frame(dim_frame(MW'(v), 5'(v * 3)), 16);
            check_dim("R6 dim sweep");
            check_disp("R6 disp unchanged");
            checks++;
            if (dim_q !== MW'(v)) begin
                errors++;
                $display("FAIL R7 dim actual %h expected %h", dim_q, MW'(v));
            end
        end
        send_frame(dim_frame(10'h3FF, 5'h1F), 16);
        check_dim("R6 max value");

        // R2: serial clock toggles while deselected, then an empty frame
        for (int i = 0; i < 20; i++) send_bit(logic'(i % 2), 1'b0);
        send_frame('0, 0);
        check_dim("R2 ignored while deselected");
        check_disp("R2 ignored while deselected");

        // R8: display frame, then an 8-bit partial with mode bit 1
        begin
            logic [FW-1:0] f;
            for (int i = 0; i < FW; i++) f[i] = logic'(i % 3 == 0);
            f[FW-1] = 1'b1;
            send_frame(f, FW);
            f = '0;
            f[7:0] = 8'b1010_0110 | 8'h80;
            send_frame(f, 8);
            check_disp("R8 partial frame keeps old bits");
        end

        // R1: reset mid-stream clears everything
        cs_n = 1'b0;
        send_bit(1'b1, 1'b1);
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        cs_n = 1'b1;
        model = '0; exp_disp = '0; exp_dim = '0;
        wait_cyc(8);
        check_disp("R1 mid reset");
        check_dim("R1 mid reset");
        send_frame('0, 0);
        check_dim("R1 shift register cleared");
        check_disp("R1 shift register cleared");

        done = 1'b1;
    end

    // watchdog and single summary line
    initial begin
        for (int c = 0; c < 190000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule